// File: doc/BRIEF.md
# Bridge Aperture Window Translator

This block maps accesses that land in one bridge aperture onto addresses in a peer partition. The aperture has two regions. The lower region is an array of lookup slots. Every slot is 64 KiB, and each slot has its own translation entry. The upper region is a single direct window. Its size and base translation are programmable, and it starts right after the last slot.

Each access gives an aperture offset with a valid strobe. One cycle later the block returns the translated address and the target partition, with exactly one of three flags raised: hit, miss or error.

Software changes the translation state through a small register write port, and only inside a lock/configure handshake. While the partition is locked, accesses are refused. A configure command returns the partition to normal operation. If an enabled direct window has a badly aligned base, the configure command reports an error instead. Software recovers by clearing that window and issuing the configure command again.

Top module: `bar_window_xlate`

## Requirements
- R1: After reset, `cfgState` is 0 (normal), all response flags are low, every slot is disabled and the direct window is disabled, so any access misses.
- R2: Whenever `cmdLock` is high, `cfgState` reads 1 (locked) one cycle later. Register writes take effect only while `cfgState` is 1 (locked) or 2 (error). A write made while it is 0 changes nothing.
- R3: A `cmdCfg` pulse without `cmdLock`, given in state 1 or 2, moves the state one cycle later:
  - to 2 if the direct window is enabled and translate bits [11:PART_W] are not all zero;
  - otherwise to 0.
  A `cmdCfg` pulse given in state 0 leaves the state at 0.
- R4: An access made while `cfgState` is not 0 returns `respErr` alone, with the address and partition at 0.
- R5: A slot entry is written with `wrSel`=0 and `wrIdx`=slot. Its fields are:
  - bit 0: enable;
  - bits [PART_W:1]: partition;
  - bits [31:16]: base.
  An access to an enabled slot hits. Its address is {base, offset[15:0]} and its partition is the entry's partition.
- R6: Slot 0 is reserved. Writes to index 0 are ignored, and offsets 0 to 0xFFFF always miss.
- R7: An access to a disabled slot misses, with the address and partition at 0.
- R8: The direct window starts at offset SLOT_CNT×64 KiB. A hit there gives the address {translate[31:12], 12'b0} + (offset − start). Its partition is translate[PART_W-1:0], and translate is written with `wrSel`=3.
- R9: The direct size register is written with `wrSel`=2. Bits [5:0] hold log2(size), ORed with the size value.
  - A write of 0 clears the size.
  - Any other write is accepted only if the log2 lies between 12 and log2(SLOT_CNT×64 KiB) and the remaining bits equal the size exactly.
  - A rejected write leaves the previous size in place.
- R10: A direct-region access misses if the window is disabled or if (offset − start) ≥ size. The window enable is bit 0 of the control register, written with `wrSel`=1.
- R11: The response appears in the cycle after `accValid` and lasts one cycle. When `respValid` is high, exactly one of hit, miss and error is set. Otherwise all three are low.
- R12: Recovery from state 2 works as follows. Software writes the control register to 0, the size to 0 and the translate register to the partition alone, then issues `cmdCfg`. The state returns to 0, and the direct window then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLock | input | 1 | Lock command pulse |
| cmdCfg | input | 1 | Configure command pulse |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 slot, 1 direct control, 2 direct size, 3 direct translate |
| wrIdx | input | IDX_W | Slot index for slot writes |
| wrData | input | OUT_W | Write data |
| accValid | input | 1 | Access strobe |
| accOff | input | OFF_W | Offset of the access within the aperture |
| respValid | output | 1 | Response valid |
| respHit | output | 1 | Access translated |
| respMiss | output | 1 | Access fell in a disabled or out-of-range window |
| respErr | output | 1 | Access refused because the partition is not normal |
| respAddr | output | OUT_W | Translated address |
| respPart | output | PART_W | Target partition |
| cfgState | output | 2 | 0 normal, 1 locked, 2 error |

## Verification
Several properties are checked by assertions on every cycle:
- the one-hot flag rule of each response and the quiet outputs between responses;
- the move to locked after any lock command;
- that a configure command always leaves the locked state, and that the normal state persists without a lock command;
- that window state stays frozen while the partition is normal;
- that a stored size never leaves its legal range;
- that slot 0 always misses.

The address arithmetic needs the bench's directed scenarios to show it. So do the direct window's offset base and the size-boundary cutoff, the rejection of each kind of malformed size word, the alignment error, and the clear-and-retry recovery.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_LOCKED = 2'd1,
    ST_ERROR  = 2'd2
  } cfgState_e;

  typedef enum logic [1:0] {
    SEL_SLOT   = 2'd0,
    SEL_DCTRL  = 2'd1,
    SEL_DSIZE  = 2'd2,
    SEL_DXLATE = 2'd3
  } wrSel_e;

  typedef struct packed {
    logic slotWr;
    logic dirCtrlWr;
    logic dirSizeWr;
    logic dirXlateWr;
    logic xlateOn;
  } ctrlStrb_t;
endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int SLOT_CNT = 8,
  parameter int OUT_W    = 32,
  parameter int PART_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdLock,
  input  logic                        cmdCfg,
  input  logic                        wrEn,
  input  logic [1:0]                  wrSel,
  input  logic [$clog2(SLOT_CNT)-1:0] wrIdx,
  input  logic [OUT_W-1:0]            wrData,
  input  logic                        dirBaseBad,
  output ctrlStrb_t                   strb,
  output logic [1:0]                  cfgState
);
  localparam int IDX_W   = $clog2(SLOT_CNT);
  localparam int MAX_LOG = 16 + IDX_W;

  cfgState_e stateQ, stateD;
  logic wrOpen;
  logic sizeOk;
  logic [5:0] reqLog;
  logic [OUT_W-1:0] reqVal;
  logic [OUT_W-1:0] wantVal;

  assign wrOpen  = (stateQ != ST_NORMAL);
  assign reqLog  = wrData[5:0];
  assign reqVal  = {wrData[OUT_W-1:6], 6'b0};
  assign wantVal = {{(OUT_W-1){1'b0}}, 1'b1} << reqLog;

  always_comb begin
    sizeOk = 1'b0;
    if (wrData == '0) begin
      sizeOk = 1'b1;
    end else if (reqLog >= 6'd12 && reqLog <= 6'(MAX_LOG) && reqVal == wantVal) begin
      sizeOk = 1'b1;
    end
  end

  always_comb begin
    strb.slotWr     = wrEn && wrOpen && (wrSel == SEL_SLOT) && (wrIdx != '0);
    strb.dirCtrlWr  = wrEn && wrOpen && (wrSel == SEL_DCTRL);
    strb.dirSizeWr  = wrEn && wrOpen && (wrSel == SEL_DSIZE) && sizeOk;
    strb.dirXlateWr = wrEn && wrOpen && (wrSel == SEL_DXLATE);
    strb.xlateOn    = !wrOpen;
  end

  always_comb begin
    stateD = stateQ;
    if (cmdLock) begin
      stateD = ST_LOCKED;
    end else if (cmdCfg && wrOpen) begin
      stateD = dirBaseBad ? ST_ERROR : ST_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_NORMAL;
    else       stateQ <= stateD;
  end

  assign cfgState = stateQ;

  // R2
  lock_to_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLock |=> (stateQ == ST_LOCKED));

  // R3
  cfg_leaves_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCfg && !cmdLock && stateQ != ST_NORMAL) |=> (stateQ != ST_LOCKED));

  // R3
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NORMAL && !cmdLock) |=> (stateQ == ST_NORMAL));
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int SLOT_CNT = 8,
  parameter int OUT_W    = 32,
  parameter int PART_W   = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrb_t                           strb,
  input  logic [$clog2(SLOT_CNT)-1:0]         wrIdx,
  input  logic [OUT_W-1:0]                    wrData,
  input  logic                                accValid,
  input  logic [$clog2(SLOT_CNT)+16:0]        accOff,
  output logic                                respValid,
  output logic                                respHit,
  output logic                                respMiss,
  output logic                                respErr,
  output logic [OUT_W-1:0]                    respAddr,
  output logic [PART_W-1:0]                   respPart,
  output logic                                dirBaseBad
);
  localparam int IDX_W   = $clog2(SLOT_CNT);
  localparam int OFF_W   = IDX_W + 17;
  localparam int BASE_W  = OUT_W - 16;
  localparam int MAX_LOG = 16 + IDX_W;

  logic [SLOT_CNT-1:0]             slotEnV;
  logic [SLOT_CNT-1:0][PART_W-1:0] slotPartV;
  logic [SLOT_CNT-1:0][BASE_W-1:0] slotBaseV;

  // Slot 0 is reserved: no storage, always disabled.
  for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
    if (i == 0) begin : g_rsvd
      assign slotEnV[i]   = 1'b0;
      assign slotPartV[i] = '0;
      assign slotBaseV[i] = '0;
    end else begin : g_live
      logic              enQ;
      logic [PART_W-1:0] partQ;
      logic [BASE_W-1:0] baseQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          enQ   <= 1'b0;
          partQ <= '0;
          baseQ <= '0;
        end else if (strb.slotWr && wrIdx == IDX_W'(i)) begin
          enQ   <= wrData[0];
          partQ <= wrData[PART_W:1];
          baseQ <= wrData[OUT_W-1:16];
        end
      end
      assign slotEnV[i]   = enQ;
      assign slotPartV[i] = partQ;
      assign slotBaseV[i] = baseQ;
    end
  end

  logic             dirEn;
  logic             dirSizeOn;
  logic [5:0]       dirLog;
  logic [OUT_W-1:0] dirXlate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirEn     <= 1'b0;
      dirSizeOn <= 1'b0;
      dirLog    <= '0;
      dirXlate  <= '0;
    end else begin
      if (strb.dirCtrlWr) dirEn <= wrData[0];
      if (strb.dirSizeWr) begin
        dirSizeOn <= (wrData != '0);
        dirLog    <= wrData[5:0];
      end
      if (strb.dirXlateWr) dirXlate <= wrData;
    end
  end

  assign dirBaseBad = dirEn && (dirXlate[11:PART_W] != '0);

  logic             inSlots;
  logic [IDX_W-1:0] slotSel;
  logic [OFF_W-2:0] dirRel;
  logic [OFF_W-1:0] dirSpan;
  logic             inWin;
  logic             hitD, missD, errD;
  logic [OUT_W-1:0] addrD;
  logic [PART_W-1:0] partD;

  assign inSlots = !accOff[OFF_W-1];
  assign slotSel = accOff[16+IDX_W-1:16];
  assign dirRel  = accOff[OFF_W-2:0];
  assign dirSpan = {{(OFF_W-1){1'b0}}, 1'b1} << dirLog;
  assign inWin   = dirEn && dirSizeOn && ({1'b0, dirRel} < dirSpan);

  always_comb begin
    hitD  = 1'b0;
    missD = 1'b0;
    errD  = 1'b0;
    addrD = '0;
    partD = '0;
    if (!strb.xlateOn) begin
      errD = 1'b1;
    end else if (inSlots) begin
      if (slotEnV[slotSel]) begin
        hitD  = 1'b1;
        addrD = {slotBaseV[slotSel], accOff[15:0]};
        partD = slotPartV[slotSel];
      end else begin
        missD = 1'b1;
      end
    end else if (inWin) begin
      hitD  = 1'b1;
      addrD = {dirXlate[OUT_W-1:12], 12'b0} + OUT_W'(dirRel);
      partD = dirXlate[PART_W-1:0];
    end else begin
      missD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respErr   <= 1'b0;
      respAddr  <= '0;
      respPart  <= '0;
    end else begin
      respValid <= accValid;
      respHit   <= accValid && hitD;
      respMiss  <= accValid && missD;
      respErr   <= accValid && errD;
      respAddr  <= accValid ? addrD : '0;
      respPart  <= accValid ? partD : '0;
    end
  end

  // R11
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones({respHit, respMiss, respErr}) == 1));

  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> ({respHit, respMiss, respErr} == 3'b000));

  // R4
  locked_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !strb.xlateOn) |=> respErr);

  // R2
  normal_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xlateOn |=> ($stable(dirEn) && $stable(dirLog) && $stable(dirXlate) && $stable(slotEnV)));

  // R9
  size_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirSizeOn |-> (dirLog >= 6'd12 && dirLog <= 6'(MAX_LOG)));

  // R6
  slot0_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && strb.xlateOn && inSlots && slotSel == '0) |=> respMiss);
endmodule

// File: rtl/bar_window_xlate.sv
module bar_window_xlate
  import wt_pkg::*;
#(
  parameter int SLOT_CNT = 8,
  parameter int OUT_W    = 32,
  parameter int PART_W   = 4,
  localparam int IDX_W   = $clog2(SLOT_CNT),
  localparam int OFF_W   = IDX_W + 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLock,
  input  logic              cmdCfg,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [OUT_W-1:0]  wrData,
  input  logic              accValid,
  input  logic [OFF_W-1:0]  accOff,
  output logic              respValid,
  output logic              respHit,
  output logic              respMiss,
  output logic              respErr,
  output logic [OUT_W-1:0]  respAddr,
  output logic [PART_W-1:0] respPart,
  output logic [1:0]        cfgState
);
  ctrlStrb_t strb;
  logic dirBaseBad;

  wt_ctrl #(.SLOT_CNT(SLOT_CNT), .OUT_W(OUT_W), .PART_W(PART_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdLock(cmdLock), .cmdCfg(cmdCfg),
    .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx), .wrData(wrData),
    .dirBaseBad(dirBaseBad), .strb(strb), .cfgState(cfgState)
  );

  wt_datapath #(.SLOT_CNT(SLOT_CNT), .OUT_W(OUT_W), .PART_W(PART_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .accValid(accValid), .accOff(accOff),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss), .respErr(respErr),
    .respAddr(respAddr), .respPart(respPart), .dirBaseBad(dirBaseBad)
  );
endmodule

// File: tb/bar_window_xlate_tb.sv
module bar_window_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdLock = 1'b0, cmdCfg = 1'b0, wrEn = 1'b0, accValid = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [19:0] accOff = '0;
  logic        respValid, respHit, respMiss, respErr;
  logic [31:0] respAddr;
  logic [3:0]  respPart;
  logic [1:0]  cfgState;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_window_xlate u_dut (
    .clk(clk), .rstN(rstN), .cmdLock(cmdLock), .cmdCfg(cmdCfg),
    .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx), .wrData(wrData),
    .accValid(accValid), .accOff(accOff),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss), .respErr(respErr),
    .respAddr(respAddr), .respPart(respPart), .cfgState(cfgState)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input logic [1:0] exp);
    chk(cfgState == exp, req, 64'(cfgState), 64'(exp));
  endtask

  // flags packed as {valid,hit,miss,err}
  task automatic access(input string req, input logic [19:0] off,
                        input logic [3:0] expFlags, input logic [31:0] expAddr, input logic [3:0] expPart);
    logic [39:0] act, exp;
    @(negedge clk); accValid = 1'b1; accOff = off;
    @(negedge clk); accValid = 1'b0;
    act = {respValid, respHit, respMiss, respErr, respPart, respAddr};
    exp = {expFlags, expPart, expAddr};
    chk(act == exp, req, 64'(act), 64'(exp));
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrIdx = idx; wrData = data;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doLock();
    @(negedge clk); cmdLock = 1'b1;
    @(negedge clk); cmdLock = 1'b0;
  endtask

  task automatic doCfg();
    @(negedge clk); cmdCfg = 1'b1;
    @(negedge clk); cmdCfg = 1'b0;
  endtask

  localparam logic [3:0] F_HIT  = 4'b1100;
  localparam logic [3:0] F_MISS = 4'b1010;
  localparam logic [3:0] F_ERR  = 4'b1001;

  task automatic tReset();
    chkState("R1 reset state", 2'd0);
    chk({respValid, respHit, respMiss, respErr} == 4'b0, "R1 reset flags",
        64'({respValid, respHit, respMiss, respErr}), 64'd0);
    access("R1 slot disabled after reset", 20'h1_2345, F_MISS, 32'h0, 4'h0);
    access("R1 direct disabled after reset", 20'h8_0010, F_MISS, 32'h0, 4'h0);
  endtask

  task automatic tTiming();
    @(negedge clk); accValid = 1'b1; accOff = 20'h0_0000;
    @(negedge clk); accValid = 1'b0;
    chk(respValid == 1'b1, "R11 response one cycle later", 64'(respValid), 64'd1);
    @(negedge clk);
    chk({respValid, respHit, respMiss, respErr} == 4'b0, "R11 response lasts one cycle",
        64'({respValid, respHit, respMiss, respErr}), 64'd0);
  endtask

  task automatic tWriteWhileNormal();
    regWrite(2'd0, 3'd1, 32'hABCD_000B);
    access("R2 write in normal ignored", 20'h1_2345, F_MISS, 32'h0, 4'h0);
    doCfg();
    chkState("R3 cfg in normal keeps normal", 2'd0);
  endtask

  task automatic tLock();
    doLock();
    chkState("R2 lock moves to locked", 2'd1);
    access("R4 access while locked errors", 20'h1_2345, F_ERR, 32'h0, 4'h0);
  endtask

  task automatic tSlots();
    regWrite(2'd0, 3'd1, 32'hABCD_000B);
    regWrite(2'd0, 3'd2, 32'h5555_0004);
    regWrite(2'd0, 3'd0, 32'h1111_000B);
    regWrite(2'd0, 3'd7, 32'h7700_0003);
    doCfg();
    chkState("R3 cfg returns to normal", 2'd0);
    access("R5 slot1 translation", 20'h1_2345, F_HIT, 32'hABCD_2345, 4'h5);
    access("R5 slot7 translation", 20'h7_FFFF, F_HIT, 32'h7700_FFFF, 4'h1);
    access("R6 slot0 reserved", 20'h0_0100, F_MISS, 32'h0, 4'h0);
    access("R7 slot2 disabled", 20'h2_0000, F_MISS, 32'h0, 4'h0);
  endtask

  task automatic tDirect();
    doLock();
    regWrite(2'd1, 3'd0, 32'h0000_0001);
    regWrite(2'd2, 3'd0, 32'h0001_0010);
    regWrite(2'd3, 3'd0, 32'h4000_0003);
    doCfg();
    chkState("R3 aligned direct cfg normal", 2'd0);
    access("R8 direct translation", 20'h8_1234, F_HIT, 32'h4000_1234, 4'h3);
    access("R8 direct window start", 20'h8_0000, F_HIT, 32'h4000_0000, 4'h3);
    access("R10 direct beyond size", 20'h9_0000, F_MISS, 32'h0, 4'h0);
  endtask

  task automatic tSizeRules();
    doLock();
    regWrite(2'd2, 3'd0, 32'h0000_080B);
    regWrite(2'd2, 3'd0, 32'h0010_0014);
    regWrite(2'd2, 3'd0, 32'h0002_0010);
    doCfg();
    access("R9 bad size writes ignored, last byte", 20'h8_FFFF, F_HIT, 32'h4000_FFFF, 4'h3);
    access("R9 bad size writes ignored, edge", 20'h9_0000, F_MISS, 32'h0, 4'h0);
    doLock();
    regWrite(2'd2, 3'd0, 32'h0008_0013);
    doCfg();
    access("R9 max size accepted", 20'hF_FFFF, F_HIT, 32'h4007_FFFF, 4'h3);
  endtask

  task automatic tErrorRecover();
    doLock();
    regWrite(2'd3, 3'd0, 32'h4000_0103);
    doCfg();
    chkState("R3 unaligned base gives error", 2'd2);
    access("R4 access in error state", 20'h8_1234, F_ERR, 32'h0, 4'h0);
    regWrite(2'd1, 3'd0, 32'h0);
    regWrite(2'd2, 3'd0, 32'h0);
    regWrite(2'd3, 3'd0, 32'h0000_0003);
    doCfg();
    chkState("R12 recovery returns normal", 2'd0);
    access("R12 cleared direct misses", 20'h8_1234, F_MISS, 32'h0, 4'h0);
    access("R10 slot region unaffected", 20'h1_0001, F_HIT, 32'hABCD_0001, 4'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTiming();
    tWriteWhileNormal();
    tLock();
    tSlots();
    tDirect();
    tSizeRules();
    tErrorRecover();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule